// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block gathers 32 raw interrupt lines, qualifies each one according to a per-source trigger code, and presents the result on two CPU request lines and one wakeup line. Software programs it through a small word-addressed register port. Every control field is changed only through a pair of addresses. Ones written to the set address turn bits on. Ones written to the clear address turn bits off. Zero bits leave the stored state as it was, so a single source can be reprogrammed without a read-modify-write sequence.

Each source carries a 3-bit trigger code held in three separate words, an enable mask, a wakeup enable, a source-select bit and a routing bit. The routing bit chooses which of the two request outputs reports the source. Raw inputs are synchronized, decoded as level-high, level-low, or edge-captured conditions, and reported through two status words. There is one status word per request output, and each shows the sources that are active, enabled by the mask and routed to that output.

Top module: `dreq_intc`

## Requirements
- R1: Each control word has its own pair of write addresses. Writing to the set address ORs the write data into the word, and writing to the clear address removes the ones in the write data. Reading the set address returns the current word. The pairs (set/clear) are: trigger bit 0 at 0/1, trigger bit 1 at 2/3, trigger bit 2 at 4/5, mask at 6/7, wakeup enable at 8/9, source select at 10/11, and routing at 12/13. Register writes take effect at the clock edge that samples them.
- R2: After reset, every control word, edge flag and status word reads 0, and req0, req1 and wake are low.
- R3: Trigger code {t2,t1,t0} = 3'b101 makes a source active while its synchronized input is 1.
- R4: Trigger code 3'b110 makes a source active while its synchronized input is 0.
- R5: Trigger codes 3'b000, 3'b100 and 3'b111 make a source never active.
- R6: In edge codes a rising edge of the synchronized input sets the source's rise flag, and a falling edge sets its fall flag. Code 3'b001 captures rising edges, 3'b010 captures falling edges, and 3'b011 captures both. An edge-coded source is active while either of its flags is set. The rise flags read at address 14 and the fall flags read at address 15.
- R7: Writing ones to address 14 clears those rise flags, and writing ones to address 15 clears those fall flags. Zero bits leave the flags unchanged.
- R8: Address 16 reads the sources that are active, masked in and routed with routing bit 1. Address 17 reads the sources that are active, masked in and routed with routing bit 0.
- R9: Address 18 reads the current mask.
- R10: req0 is the OR of the address-16 status word, and req1 is the OR of the address-17 status word.
- R11: wake is high exactly when some source is active, masked in and wakeup-enabled.
- R12: A source whose source-select bit is 0 is never active.
- R13: A change on a raw input reaches the level status after two clock edges, and it sets an edge flag on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| req0 | output | 1 | Request output 0 |
| req1 | output | 1 | Request output 1 |
| wake | output | 1 | Wakeup output |

## Verification
A register write is visible one clock edge after the strobe, and reads follow rd_addr within the same cycle. A raw input change appears in the level status two edges later and in an edge flag three edges later. The bench therefore drives a write and then checks only after the following falling edge. After any input change it waits four full cycles before it compares the status words or the outputs. One directed test samples just before and just after the two-edge point, which pins the latency exactly.

// File: rtl/dreq_intc_pkg.sv
package dreq_intc_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_T0_SET   = 5'd0;
    localparam logic [ADDR_W-1:0] A_T0_CLR   = 5'd1;
    localparam logic [ADDR_W-1:0] A_T1_SET   = 5'd2;
    localparam logic [ADDR_W-1:0] A_T1_CLR   = 5'd3;
    localparam logic [ADDR_W-1:0] A_T2_SET   = 5'd4;
    localparam logic [ADDR_W-1:0] A_T2_CLR   = 5'd5;
    localparam logic [ADDR_W-1:0] A_MSK_SET  = 5'd6;
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = 5'd7;
    localparam logic [ADDR_W-1:0] A_WK_SET   = 5'd8;
    localparam logic [ADDR_W-1:0] A_WK_CLR   = 5'd9;
    localparam logic [ADDR_W-1:0] A_SEL_SET  = 5'd10;
    localparam logic [ADDR_W-1:0] A_SEL_CLR  = 5'd11;
    localparam logic [ADDR_W-1:0] A_RT_SET   = 5'd12;
    localparam logic [ADDR_W-1:0] A_RT_CLR   = 5'd13;
    localparam logic [ADDR_W-1:0] A_RISE     = 5'd14;
    localparam logic [ADDR_W-1:0] A_FALL     = 5'd15;
    localparam logic [ADDR_W-1:0] A_STAT0    = 5'd16;
    localparam logic [ADDR_W-1:0] A_STAT1    = 5'd17;
    localparam logic [ADDR_W-1:0] A_MSK_RD   = 5'd18;

    localparam logic [2:0] TRG_OFF  = 3'b000;
    localparam logic [2:0] TRG_RISE = 3'b001;
    localparam logic [2:0] TRG_FALL = 3'b010;
    localparam logic [2:0] TRG_BOTH = 3'b011;
    localparam logic [2:0] TRG_HIGH = 3'b101;
    localparam logic [2:0] TRG_LOW  = 3'b110;
endpackage

// File: rtl/dreq_intc_sync.sv
module dreq_intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now_o  = st_q.s2;
    assign prev_o = st_q.s3;
endmodule

// File: rtl/dreq_intc_trig.sv
module dreq_intc_trig
    import dreq_intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] sig,
    input  logic [N-1:0] sig_prev,
    input  logic [N-1:0] t0,
    input  logic [N-1:0] t1,
    input  logic [N-1:0] t2,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] rise_f,
    input  logic [N-1:0] fall_f,
    output logic [N-1:0] active,
    output logic [N-1:0] rise_hit,
    output logic [N-1:0] fall_hit
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic [2:0] code;
        logic       lvl;
        assign code = {t2[i], t1[i], t0[i]};

        always_comb begin
            lvl = 1'b0;
            case (code)
                TRG_HIGH: lvl = sig[i];
                TRG_LOW:  lvl = ~sig[i];
                TRG_RISE, TRG_FALL, TRG_BOTH: lvl = rise_f[i] | fall_f[i];
                default:  lvl = 1'b0;
            endcase
        end

        assign active[i]   = lvl & sel[i];
        assign rise_hit[i] = sig[i] & ~sig_prev[i] &
                             ((code == TRG_RISE) || (code == TRG_BOTH));
        assign fall_hit[i] = ~sig[i] & sig_prev[i] &
                             ((code == TRG_FALL) || (code == TRG_BOTH));
    end
endmodule

// File: rtl/dreq_intc_regs.sv
module dreq_intc_regs
    import dreq_intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic [N-1:0]      rise_hit,
    input  logic [N-1:0]      fall_hit,
    output logic [N-1:0]      t0_o,
    output logic [N-1:0]      t1_o,
    output logic [N-1:0]      t2_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      wk_o,
    output logic [N-1:0]      sel_o,
    output logic [N-1:0]      rt_o,
    output logic [N-1:0]      rise_o,
    output logic [N-1:0]      fall_o
);
    typedef struct packed {
        logic [N-1:0] t0;
        logic [N-1:0] t1;
        logic [N-1:0] t2;
        logic [N-1:0] mask;
        logic [N-1:0] wk;
        logic [N-1:0] sel;
        logic [N-1:0] rt;
        logic [N-1:0] rise;
        logic [N-1:0] fall;
    } regs_t;

    regs_t rg_d, rg_q;

    function automatic logic [N-1:0] apply(input logic [N-1:0] cur,
                                           input logic         set_hit,
                                           input logic         clr_hit,
                                           input logic [N-1:0] bits);
        logic [N-1:0] v;
        v = cur;
        if (set_hit) v = v | bits;
        if (clr_hit) v = v & ~bits;
        return v;
    endfunction

    always_comb begin
        logic we_;
        we_ = wr_en;
        rg_d.t0   = apply(rg_q.t0,   we_ && wr_addr == A_T0_SET,  we_ && wr_addr == A_T0_CLR,  wr_data);
        rg_d.t1   = apply(rg_q.t1,   we_ && wr_addr == A_T1_SET,  we_ && wr_addr == A_T1_CLR,  wr_data);
        rg_d.t2   = apply(rg_q.t2,   we_ && wr_addr == A_T2_SET,  we_ && wr_addr == A_T2_CLR,  wr_data);
        rg_d.mask = apply(rg_q.mask, we_ && wr_addr == A_MSK_SET, we_ && wr_addr == A_MSK_CLR, wr_data);
        rg_d.wk   = apply(rg_q.wk,   we_ && wr_addr == A_WK_SET,  we_ && wr_addr == A_WK_CLR,  wr_data);
        rg_d.sel  = apply(rg_q.sel,  we_ && wr_addr == A_SEL_SET, we_ && wr_addr == A_SEL_CLR, wr_data);
        rg_d.rt   = apply(rg_q.rt,   we_ && wr_addr == A_RT_SET,  we_ && wr_addr == A_RT_CLR,  wr_data);
        // edge flags: clear first, fresh capture wins
        rg_d.rise = apply(rg_q.rise, 1'b0, we_ && wr_addr == A_RISE, wr_data) | rise_hit;
        rg_d.fall = apply(rg_q.fall, 1'b0, we_ && wr_addr == A_FALL, wr_data) | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign t0_o   = rg_q.t0;
    assign t1_o   = rg_q.t1;
    assign t2_o   = rg_q.t2;
    assign mask_o = rg_q.mask;
    assign wk_o   = rg_q.wk;
    assign sel_o  = rg_q.sel;
    assign rt_o   = rg_q.rt;
    assign rise_o = rg_q.rise;
    assign fall_o = rg_q.fall;
endmodule

// File: rtl/dreq_intc.sv
module dreq_intc
    import dreq_intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_SRC-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_SRC-1:0]  rd_data,
    output logic              req0,
    output logic              req1,
    output logic              wake
);
    logic [N_SRC-1:0] sig_w, prev_w, act_w, rhit_w, fhit_w;
    logic [N_SRC-1:0] t0_w, t1_w, t2_w, mask_w, wk_w, sel_w, rt_w, rise_w, fall_w;
    logic [N_SRC-1:0] stat0_w, stat1_w;

    dreq_intc_sync #(.W(N_SRC)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(irq_in), .now_o(sig_w), .prev_o(prev_w)
    );

    dreq_intc_trig #(.N(N_SRC)) trig_i (
        .sig(sig_w), .sig_prev(prev_w), .t0(t0_w), .t1(t1_w), .t2(t2_w),
        .sel(sel_w), .rise_f(rise_w), .fall_f(fall_w),
        .active(act_w), .rise_hit(rhit_w), .fall_hit(fhit_w)
    );

    dreq_intc_regs #(.N(N_SRC)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rise_hit(rhit_w), .fall_hit(fhit_w),
        .t0_o(t0_w), .t1_o(t1_w), .t2_o(t2_w), .mask_o(mask_w), .wk_o(wk_w),
        .sel_o(sel_w), .rt_o(rt_w), .rise_o(rise_w), .fall_o(fall_w)
    );

    assign stat0_w = act_w & mask_w & rt_w;
    assign stat1_w = act_w & mask_w & ~rt_w;
    assign req0    = |stat0_w;
    assign req1    = |stat1_w;
    assign wake    = |(act_w & mask_w & wk_w);

    always_comb begin
        case (rd_addr)
            A_T0_SET:  rd_data = t0_w;
            A_T1_SET:  rd_data = t1_w;
            A_T2_SET:  rd_data = t2_w;
            A_MSK_SET: rd_data = mask_w;
            A_WK_SET:  rd_data = wk_w;
            A_SEL_SET: rd_data = sel_w;
            A_RT_SET:  rd_data = rt_w;
            A_RISE:    rd_data = rise_w;
            A_FALL:    rd_data = fall_w;
            A_STAT0:   rd_data = stat0_w;
            A_STAT1:   rd_data = stat1_w;
            A_MSK_RD:  rd_data = mask_w;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dreq_intc_chk.sv
module dreq_intc_chk
    import dreq_intc_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [N-1:0]      wr_data,
    input logic              req0,
    input logic              req1,
    input logic              wake,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      rt,
    input logic [N-1:0]      wk
);
    // R10
    req0_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req0 |-> ((mask & rt) != '0));
    // R10
    req1_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req1 |-> ((mask & ~rt) != '0));
    // R11
    wake_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ((mask & wk) != '0));
    // R1
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSK_SET) |=> ((mask & $past(wr_data)) == $past(wr_data)));
    // R1
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSK_CLR) |=> ((mask & $past(wr_data)) == '0));
    // R1
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == A_MSK_SET || wr_addr == A_MSK_CLR)) |=> $stable(mask));
endmodule

bind dreq_intc dreq_intc_chk #(.N(N_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req0(req0), .req1(req1), .wake(wake), .mask(mask_w), .rt(rt_w), .wk(wk_w)
);

// File: tb/dreq_intc_tb.sv
module dreq_intc_tb_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          req0, req1, wake;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_t0 = '0, m_t1 = '0, m_t2 = '0, m_mask = '0, m_wk = '0;
    logic [N-1:0] m_sel = '0, m_rt = '0, m_rise = '0, m_fall = '0, m_in = '0;

    always #2.5 clk = ~clk;

    dreq_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .req0(req0), .req1(req1), .wake(wake)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] upd(input logic [N-1:0] c, input logic s,
                                         input logic k, input logic [N-1:0] d);
        logic [N-1:0] v;
        v = c;
        if (s) v = v | d;
        if (k) v = v & ~d;
        return v;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_t0   = upd(m_t0,   a == 0,  a == 1,  d);
        m_t1   = upd(m_t1,   a == 2,  a == 3,  d);
        m_t2   = upd(m_t2,   a == 4,  a == 5,  d);
        m_mask = upd(m_mask, a == 6,  a == 7,  d);
        m_wk   = upd(m_wk,   a == 8,  a == 9,  d);
        m_sel  = upd(m_sel,  a == 10, a == 11, d);
        m_rt   = upd(m_rt,   a == 12, a == 13, d);
        m_rise = upd(m_rise, 1'b0,    a == 14, d);
        m_fall = upd(m_fall, 1'b0,    a == 15, d);
    endtask

    task automatic drive_in(input logic [N-1:0] v);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            logic [2:0] c;
            c = {m_t2[i], m_t1[i], m_t0[i]};
            if (v[i] && !m_in[i] && (c == 3'b001 || c == 3'b011)) m_rise[i] = 1'b1;
            if (!v[i] && m_in[i] && (c == 3'b010 || c == 3'b011)) m_fall[i] = 1'b1;
        end
        irq_in = v;
        m_in = v;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [N-1:0] exp_act();
        logic [N-1:0] a;
        for (int i = 0; i < N; i++) begin
            case ({m_t2[i], m_t1[i], m_t0[i]})
                3'b101: a[i] = m_in[i];
                3'b110: a[i] = ~m_in[i];
                3'b001, 3'b010, 3'b011: a[i] = m_rise[i] | m_fall[i];
                default: a[i] = 1'b0;
            endcase
        end
        return a & m_sel;
    endfunction

    task automatic rd(input logic [4:0] a, output logic [N-1:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] v, act, s0, s1;
        act = exp_act();
        s0 = act & m_mask & m_rt;
        s1 = act & m_mask & ~m_rt;
        rd(5'd16, v); chk({tag, " R8 stat0"}, v, s0);
        rd(5'd17, v); chk({tag, " R8 stat1"}, v, s1);
        rd(5'd18, v); chk({tag, " R9 maskrd"}, v, m_mask);
        rd(5'd14, v); chk({tag, " R6 rise"}, v, m_rise);
        rd(5'd15, v); chk({tag, " R6 fall"}, v, m_fall);
        rd(5'd0,  v); chk({tag, " R1 t0"}, v, m_t0);
        rd(5'd12, v); chk({tag, " R1 route"}, v, m_rt);
        rd(5'd8,  v); chk({tag, " R1 wake_en"}, v, m_wk);
        chk({tag, " R10 req0"}, {31'd0, req0}, {31'd0, |s0});
        chk({tag, " R10 req1"}, {31'd0, req1}, {31'd0, |s1});
        chk({tag, " R11 wake"}, {31'd0, wake}, {31'd0, |(act & m_mask & m_wk)});
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        rd(5'd4, v);  chk("R2 t2 reset", v, '0);
        rd(5'd10, v); chk("R2 sel reset", v, '0);
        check_all("R2 reset");

        // R13 latency: level-high source 0 on request 0
        wr(5'd10, 32'h0000_000F); wr(5'd0, 32'h1); wr(5'd4, 32'h1);
        wr(5'd6, 32'h0000_000F); wr(5'd12, 32'h1); wr(5'd8, 32'h1);
        @(negedge clk);
        irq_in[0] = 1'b1; m_in[0] = 1'b1;
        @(negedge clk);
        chk("R13 one edge", {31'd0, req0}, 32'd0);
        @(negedge clk);
        chk("R13 two edges R3", {31'd0, req0}, 32'd1);
        repeat (2) @(negedge clk);
        check_all("R3 high");

        // R4 level low on source 1, request 1
        wr(5'd2, 32'h2); wr(5'd4, 32'h2);
        check_all("R4 low");
        drive_in(32'h3);
        check_all("R4 low deasserted");

        // R5 disabled codes 100 and 111
        wr(5'd3, 32'h2); wr(5'd0, 32'h2); wr(5'd2, 32'h2);
        check_all("R5 code 111");
        wr(5'd1, 32'h2); wr(5'd3, 32'h2);
        drive_in(32'h1);
        check_all("R5 code 100");

        // R6 / R7 edge capture on source 2 (both edges) and clear
        wr(5'd0, 32'h4); wr(5'd2, 32'h4);
        check_all("R6 armed");
        drive_in(32'h5);
        check_all("R6 rise");
        drive_in(32'h1);
        check_all("R6 fall");
        wr(5'd14, 32'h0000_0000);
        check_all("R7 zero clear");
        wr(5'd14, 32'h4);
        check_all("R7 rise clr");
        wr(5'd15, 32'h4);
        check_all("R7 fall clr");

        // R12 source select gates activity
        wr(5'd11, 32'h1);
        check_all("R12 sel off");
        wr(5'd10, 32'h1);

        // mask clear removes source
        wr(5'd7, 32'h1);
        check_all("R1 mask clr");

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            logic [4:0] a;
            a = 5'($urandom_range(0, 15));
            wr(a, $urandom());
            if ($urandom_range(0, 1) == 1) drive_in($urandom());
            else @(negedge clk);
            check_all("R1 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule